// File: doc/BRIEF.md
# Dual-Clock Ready-Flag FIFO

This block carries 36-bit words from a write-clock domain to a read-clock domain. The two clocks may be unrelated or may share a source. Each side sees only flags that are registered in its own clock. The write side gets an input-ready flag and an active-low almost-full flag. The read side gets an output-ready flag and an active-low almost-empty flag.

The read side works in first-word-fall-through fashion. Whenever output-ready is high, the oldest stored word already sits in the read output register, so a read simply accepts it. The position of each pointer crosses to the other domain as Gray code through a two-stage synchronizer, and each side computes its fill level from its own pointer and the synchronized copy of the other one. Both threshold levels are plain inputs.

One active-high reset input serves both sides. It may change at any time relative to either clock, and it must stay high for at least four rising edges of each clock. Each domain samples it into a local register and resets its own logic from that register. `DEPTH` must be a power of two.

Top module: `xclk_ready_fifo`

## Requirements
- R1: Words leave on `rd_data` in the order they were written, with no loss and no duplication, under any pattern of `wr_en` and `rd_en`.
- R2: While reset is held (four or more edges of each clock), `in_ready` = 0, `out_ready` = 0, `almost_empty_n` = 0 and `almost_full_n` = 1.
- R3: Count as edge 1 the first rising `wclk` edge that samples `rst` low. `in_ready` is still 0 after edge 1 and is 1 after edge 2.
- R4: With no reads, the FIFO accepts exactly DEPTH+1 words: DEPTH in the array and one in the read output register. `in_ready` then reads 0, and a write presented while `in_ready` is 0 is dropped.
- R5: A read presented while `out_ready` is 0 is ignored, and no later word is lost or skipped because of it.
- R6: When a word is written into an empty FIFO at a `wclk` edge, `out_ready` is still 0 after the second rising `rclk` edge following that write. It is 1 after the third, and at that point `rd_data` already shows the word.
- R7: While `out_ready` = 1 and `rd_en` = 0, both `out_ready` and `rd_data` hold their values.
- R8: Once its view has settled, `almost_empty_n` is 0 exactly when the number of words held is at or below `ae_level`. Words held means the words in the array plus the word in the output register.
- R9: `almost_full_n` is 0 exactly when the number of free array locations is at or below `af_level`. Free locations means DEPTH minus the words written but not yet moved into the output register. The write side's own writes update the flag on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, may be asynchronous to both clocks |
| wr_en | input | 1 | Write request, taken on `wclk` when `in_ready` is 1 |
| wr_data | input | 36 | Word to write |
| af_level | input | 10 | Almost-full threshold in free locations |
| in_ready | output | 1 | 1 = room for a write |
| almost_full_n | output | 1 | 0 = free locations at or below `af_level` |
| rd_en | input | 1 | Read request, taken on `rclk` when `out_ready` is 1 |
| ae_level | input | 10 | Almost-empty threshold in stored words |
| rd_data | output | 36 | Oldest word, valid while `out_ready` is 1 |
| out_ready | output | 1 | 1 = `rd_data` holds a word |
| almost_empty_n | output | 1 | 0 = stored words at or below `ae_level` |

## Verification
The bench tries the data path with four patterns, and each one separates a different class of fault. A lone word written into an empty FIFO with reads held off pins down the exact read-edge latency of the ready flag. A burst of read requests against an empty FIFO followed by a short write run exposes a read pointer that moves when it should not. A no-read fill to capacity followed by forced writes against a low input-ready finds capacity and drop errors, and it also probes the almost-full boundary at 504 and 505 words. A long stream with random gaps on both sides checks ordering across the clock crossing, and a four-versus-five word fill checks the almost-empty boundary including the output register.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    parameter int unsigned DATA_W_DEF  = 36;
    parameter int unsigned DEPTH_DEF   = 512;
    parameter int unsigned SYNC_STAGES = 2;

    // ready: side may transfer; almost_n: active-low level flag
    typedef struct packed {
        logic ready;
        logic almost_n;
    } port_flags_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync #(
    parameter int unsigned PW     = 10,
    parameter int unsigned STAGES = xfifo_pkg::SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) stg[s] <= '0;
        end else begin
            stg[0] <= gray_in;
            for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
        end
    end

    assign bin_out = PW'(xfifo_pkg::from_gray(32'(stg[STAGES-1])));
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int unsigned W     = 36,
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/xfifo_wr_side.sv
module xfifo_wr_side
    import xfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] af_level,
    input  logic [PW-1:0] rgray,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wptr,
    output logic          rst_q,
    output port_flags_t   flags
);
    logic [PW-1:0] rbin, wptr_nx, used_nx, free_nx;

    xfifo_ptr_sync #(.PW(PW)) u_rsync (
        .clk(wclk), .rst(rst_q), .gray_in(rgray), .bin_out(rbin)
    );

    always_comb begin
        we      = wr_en & flags.ready;
        wptr_nx = wptr + PW'(we);
        used_nx = wptr_nx - rbin;
        free_nx = PW'(DEPTH) - used_nx;
    end

    always_ff @(posedge wclk) begin
        rst_q <= rst;
        if (rst_q) begin
            wptr  <= '0;
            wgray <= '0;
            flags <= '{ready: 1'b0, almost_n: 1'b1};
        end else begin
            wptr           <= wptr_nx;
            wgray          <= PW'(to_gray(32'(wptr_nx)));
            flags.ready    <= (used_nx != PW'(DEPTH));
            flags.almost_n <= (free_nx > af_level);
        end
    end

    assign waddr = wptr[AW-1:0];
endmodule

// File: rtl/xfifo_rd_side.sv
module xfifo_rd_side
    import xfifo_pkg::*;
#(
    parameter int unsigned W     = 36,
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] ae_level,
    input  logic [PW-1:0] wgray,
    input  logic [W-1:0]  ram_q,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [W-1:0]  rd_data,
    output port_flags_t   flags
);
    logic          rst_q;
    logic [PW-1:0] rptr, wbin, rptr_nx, held_nx;
    logic          take, load, rdy_nx;

    xfifo_ptr_sync #(.PW(PW)) u_wsync (
        .clk(rclk), .rst(rst_q), .gray_in(wgray), .bin_out(wbin)
    );

    always_comb begin
        take    = rd_en & flags.ready;
        load    = (wbin != rptr) & (take | ~flags.ready);
        rptr_nx = rptr + PW'(load);
        rdy_nx  = load | (flags.ready & ~take);
        held_nx = (wbin - rptr_nx) + PW'(rdy_nx);
    end

    always_ff @(posedge rclk) begin
        rst_q <= rst;
        if (rst_q) begin
            rptr    <= '0;
            rgray   <= '0;
            rd_data <= '0;
            flags   <= '{ready: 1'b0, almost_n: 1'b0};
        end else begin
            rptr           <= rptr_nx;
            rgray          <= PW'(to_gray(32'(rptr_nx)));
            if (load) rd_data <= ram_q;
            flags.ready    <= rdy_nx;
            flags.almost_n <= (held_nx > ae_level);
        end
    end

    assign raddr = rptr[AW-1:0];
endmodule

// File: rtl/xclk_ready_fifo.sv
module xclk_ready_fifo
    import xfifo_pkg::*;
#(
    parameter int unsigned W     = DATA_W_DEF,
    parameter int unsigned DEPTH = DEPTH_DEF,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [PW-1:0] af_level,
    output logic          in_ready,
    output logic          almost_full_n,
    input  logic          rd_en,
    input  logic [PW-1:0] ae_level,
    output logic [W-1:0]  rd_data,
    output logic          out_ready,
    output logic          almost_empty_n
);
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, w_ptr;
    logic          w_rst;
    logic [W-1:0]  ram_q;
    port_flags_t   wflags, rflags;

    xfifo_wr_side #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .rst(rst), .wr_en(wr_en), .af_level(af_level),
        .rgray(rgray), .we(we), .waddr(waddr), .wgray(wgray),
        .wptr(w_ptr), .rst_q(w_rst), .flags(wflags)
    );

    xfifo_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(ram_q)
    );

    xfifo_rd_side #(.W(W), .DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst(rst), .rd_en(rd_en), .ae_level(ae_level),
        .wgray(wgray), .ram_q(ram_q), .raddr(raddr), .rgray(rgray),
        .rd_data(rd_data), .flags(rflags)
    );

    assign in_ready       = wflags.ready;
    assign almost_full_n  = wflags.almost_n;
    assign out_ready      = rflags.ready;
    assign almost_empty_n = rflags.almost_n;
endmodule

// File: rtl/xclk_ready_fifo_chk.sv
module xclk_ready_fifo_chk #(
    parameter int unsigned W  = 36,
    parameter int unsigned PW = 10
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wr_en,
    input logic          in_ready,
    input logic          almost_full_n,
    input logic          rd_en,
    input logic          out_ready,
    input logic          almost_empty_n,
    input logic [W-1:0]  rd_data,
    input logic [PW-1:0] w_ptr,
    input logic          w_rst
);
    logic w_arm;
    always_ff @(posedge wclk) w_arm <= !w_rst;

    // R4: a write against a low input-ready leaves the write pointer alone
    a_r4_blocked_write: assert property (@(posedge wclk) disable iff (rst)
        (!in_ready && wr_en) |=> $stable(w_ptr));

    // R1: the write pointer advances by at most one word per edge
    a_r1_ptr_step: assert property (@(posedge wclk) disable iff (rst)
        (w_ptr == $past(w_ptr)) || (w_ptr == PW'($past(w_ptr) + 1'b1)));

    // R7: an idle read holds the presented word
    a_r7_idle_hold: assert property (@(posedge rclk) disable iff (rst)
        (out_ready && !rd_en) |=> (out_ready && $stable(rd_data)));

    // R9: zero free locations is always at or below the almost-full level
    a_r9_full_is_af: assert property (@(posedge wclk) disable iff (rst)
        (w_arm && !in_ready) |-> !almost_full_n);

    // R8: zero held words is always at or below the almost-empty level
    a_r8_empty_is_ae: assert property (@(posedge rclk) disable iff (rst)
        !out_ready |-> !almost_empty_n);
endmodule

bind xclk_ready_fifo xclk_ready_fifo_chk #(.W(W), .PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en),
    .in_ready(in_ready), .almost_full_n(almost_full_n), .rd_en(rd_en),
    .out_ready(out_ready), .almost_empty_n(almost_empty_n),
    .rd_data(rd_data), .w_ptr(w_ptr), .w_rst(w_rst)
);

// File: tb/sim_xclk_ready_fifo.sv
module sim_xclk_ready_fifo;
    localparam int W     = 36;
    localparam int DEPTH = 512;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic          wclk, rclk, rst, wr_en, rd_en;
    logic [W-1:0]  wr_data, rd_data;
    logic [PW-1:0] af_level, ae_level;
    logic          in_ready, almost_full_n, out_ready, almost_empty_n;

    int errors = 0, checks = 0, rmode = 0;
    bit done = 0;
    logic [W-1:0] sb [$];

    xclk_ready_fifo #(.W(W), .DEPTH(DEPTH)) u0 (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .af_level(af_level), .in_ready(in_ready), .almost_full_n(almost_full_n),
        .rd_en(rd_en), .ae_level(ae_level), .rd_data(rd_data),
        .out_ready(out_ready), .almost_empty_n(almost_empty_n)
    );

    initial begin wclk = 0; forever #5 wclk = ~wclk; end
    initial begin rclk = 0; #3; forever #5 rclk = ~rclk; end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // driver: holds the request until an edge with input-ready high takes it
    task automatic wr_word(input logic [W-1:0] d);
        logic acc;
        wr_data = d;
        wr_en   = 1;
        do begin
            @(negedge wclk); acc = in_ready;
            @(posedge wclk);
        end while (!acc);
        sb.push_back(d);
        #1 wr_en = 0;
    endtask

    task automatic drain();
        rmode = 1;
        wait (sb.size() == 0);
        repeat (8) @(posedge rclk);
        #1 chk(out_ready == 0, "R1 empty after drain", W'(out_ready), 0);
        chk(almost_empty_n == 0, "R8 empty after drain", W'(almost_empty_n), 0);
        rmode = 0;
    endtask

    // reader
    initial begin
        rd_en = 0;
        forever begin
            @(posedge rclk); #2;
            case (rmode)
                0:       rd_en = 0;
                1:       rd_en = 1;
                default: rd_en = 1'($urandom % 2);
            endcase
        end
    end

    // monitor: a word is taken at the next rclk edge when ready and enabled
    initial begin
        forever begin
            @(negedge rclk);
            if (!rst && out_ready && rd_en) begin
                if (sb.size() == 0)
                    chk(0, "R4 unexpected word", rd_data, 0);
                else begin
                    logic [W-1:0] e;
                    e = sb.pop_front();
                    chk(rd_data == e, "R1 order", rd_data, e);
                end
            end
        end
    end

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst = 1; wr_en = 0; wr_data = '0;
        ae_level = PW'(4); af_level = PW'(8);
        repeat (6) @(posedge wclk);
        @(negedge wclk);
        chk(in_ready == 0, "R2 in_ready", W'(in_ready), 0);
        chk(almost_full_n == 1, "R2 almost_full_n", W'(almost_full_n), 1);
        @(negedge rclk);
        chk(out_ready == 0, "R2 out_ready", W'(out_ready), 0);
        chk(almost_empty_n == 0, "R2 almost_empty_n", W'(almost_empty_n), 0);

        // R3: release between edges
        @(posedge wclk); #2 rst = 0;
        @(posedge wclk); #1 chk(in_ready == 0, "R3 after edge 1", W'(in_ready), 0);
        @(posedge wclk); #1 chk(in_ready == 1, "R3 after edge 2", W'(in_ready), 1);
        repeat (4) @(posedge rclk);

        // R6: latency of a lone word
        wr_word(36'h0_1234_5678);
        @(posedge rclk); @(posedge rclk);
        #1 chk(out_ready == 0, "R6 after read edge 2", W'(out_ready), 0);
        @(posedge rclk);
        #1 chk(out_ready == 1, "R6 after read edge 3", W'(out_ready), 1);
        chk(rd_data == 36'h0_1234_5678, "R6 word present", rd_data, 36'h0_1234_5678);
        drain();

        // R5: reads against an empty FIFO, then a short run
        rmode = 1;
        repeat (10) @(posedge rclk);
        #1 chk(out_ready == 0, "R5 empty while reading", W'(out_ready), 0);
        @(posedge wclk); #1;
        for (int i = 0; i < 3; i++) wr_word(W'(36'hA00 + i));
        drain();

        // R8: almost-empty boundary at level 4
        @(posedge wclk); #1;
        for (int i = 0; i < 4; i++) wr_word(W'(36'hB00 + i));
        repeat (8) @(posedge rclk);
        @(negedge rclk);
        chk(almost_empty_n == 0, "R8 four held", W'(almost_empty_n), 0);
        @(posedge wclk); #1;
        wr_word(36'hB04);
        repeat (8) @(posedge rclk);
        @(negedge rclk);
        chk(almost_empty_n == 1, "R8 five held", W'(almost_empty_n), 1);
        drain();

        // R9 and R4: fill without reads
        @(posedge wclk); #1;
        for (int i = 0; i < 504; i++) wr_word(W'(36'hC_0000 + i));
        repeat (8) @(posedge wclk);
        @(negedge wclk);
        chk(almost_full_n == 1, "R9 nine free", W'(almost_full_n), 1);
        chk(in_ready == 1, "R4 room left", W'(in_ready), 1);
        @(posedge wclk); #1;
        wr_word(36'hC_01F8);
        @(negedge wclk);
        chk(almost_full_n == 0, "R9 eight free", W'(almost_full_n), 0);
        @(posedge wclk); #1;
        for (int i = 0; i < 8; i++) wr_word(W'(36'hC_0200 + i));
        chk(in_ready == 0, "R4 full after DEPTH+1", W'(in_ready), 0);
        wr_data = 36'hD_EAD0; wr_en = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge wclk);
            chk(in_ready == 0, "R4 write dropped", W'(in_ready), 0);
        end
        @(posedge wclk); #1 wr_en = 0;
        drain();

        // R1: random stream on both sides
        rmode = 2;
        @(posedge wclk); #1;
        for (int i = 0; i < 300; i++) begin
            wr_word(W'($urandom));
            repeat ($urandom % 3) @(posedge wclk);
            #1;
        end
        drain();

        summary();
    end
endmodule